// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits beside one channel's receive path and decides when the host should be interrupted about messages that have been placed in its receive buffer. Each deposited message arrives as a one-cycle pulse. The block counts these pulses and raises its interrupt when either of two things happens first: the pending count reaches a programmed count limit, or a programmed number of 100 µs ticks has elapsed while at least one message is pending.

When it fires, the block captures a 32-bit status word. This word holds a rolling 4-bit tag, the number of messages in the batch, and a flag that records whether the transmit engine consumed a link record since the previous snapshot. It then stays frozen until the host acknowledges the batch. To acknowledge, the host writes the tag that follows the one it saw. Any other value is ignored. Messages that arrive while the block is frozen are counted into the next batch.

A small control word has separate set and clear addresses. It holds the receive path in reset, enables the interrupt output, and selects uncached buffer memory.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, `irq` is low, `status` is zero, `path_hold` is 1, `uncached` is 0, the tag is 0 and awaits an acknowledge of 1, the count limit is 16 and the time limit is 10 ticks.
- R2: With the controller armed, the interrupt asserts on the edge after the pending count reaches the count limit. The status word then holds the tag in bits 3:0 and the batch count in bits 10:4.
- R3: With at least one message pending and the count limit not reached, the interrupt asserts once the time limit has elapsed in ticks of TICK_DIV clocks. A limit register write (`reg_sel`=2) takes the count limit from bits 7:0 and the time limit from bits 15:8.
- R4: An acknowledge (`reg_sel`=3) whose bits 3:0 equal the current tag plus one, modulo 16, re-arms the controller and drops `irq` on the next edge. The tag then advances, wrapping from 15 to 0.
- R5: An acknowledge with any other tag value changes neither `irq` nor `status`.
- R6: While an interrupt is awaiting its acknowledge, `status` stays frozen and no new interrupt is raised. Messages arriving meanwhile are counted into the next batch.
- R7: While bit 17 of the control word (path reset) is set, message pulses are ignored, the pending count is cleared and no interrupt is raised.
- R8: `irq` is the pending interrupt gated by control bit 18 (interrupt enable). Clearing the bit lowers `irq`, and setting it again restores `irq` while the batch is still unacknowledged.
- R9: A `tx_link` pulse sets bit 16 of the next captured status word. That capture clears the flag, so the following batch has bit 16 at 0.
- R10: The count field of the status word saturates at 127.
- R11: A write with `reg_sel`=0 sets, and a write with `reg_sel`=1 clears, each control bit that is 1 in `reg_wdata` bits 18:16. Bit 16 drives `uncached` and bit 17 drives `path_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control set, 1 control clear, 2 limits, 3 acknowledge |
| reg_wdata | input | 32 | Register write data |
| msg_in | input | 1 | One message deposited in the receive buffer |
| tx_link | input | 1 | Transmit engine consumed a link record |
| irq | output | 1 | Interrupt request, level |
| status | output | 32 | Frozen status word of the current batch |
| uncached | output | 1 | Uncached buffer memory selected |
| path_hold | output | 1 | Receive path held in reset |

## Verification
A message sampled on edge E is counted after E. A count-limit interrupt is therefore captured on E+1 and is visible at the falling edge after that, which is where the bench samples `irq` and `status` after the last message of a batch. An acknowledge sampled on edge A clears `irq` at the next falling edge. If messages were already pending, the next batch is captured one edge later, so the bench checks the low level and the new status on successive falling edges. A timeout can land anywhere within one tick period, so the bench checks that `irq` is still low before the earliest possible tick count and high after the latest.

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer #(
  parameter int TICK_DIV     = 20000,
  parameter int CNT_W        = 8,
  parameter int DEF_CNT_LIM  = 16,
  parameter int DEF_TIME_LIM = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        msg_in,
  input  logic        tx_link,
  output logic        irq,
  output logic [31:0] status,
  output logic        uncached,
  output logic        path_hold
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [7:0]       cnt_lim, time_lim, ticks;
  logic [CNT_W-1:0] pend;
  logic [3:0]       tag;
  logic             ien, armed, irq_pend, link_q;
  logic [31:0]      status_q;

  wire tick    = (div_q == DIV_W'(TICK_DIV - 1));
  wire ack_hit = reg_we && reg_sel == 2'd3 && !armed && reg_wdata[3:0] == tag + 4'd1;
  wire fire    = armed && !path_hold && pend != '0 &&
                 (pend >= CNT_W'(cnt_lim) || ticks >= time_lim);
  wire [6:0] cnt7 = (pend > CNT_W'(127)) ? 7'd127 : 7'(pend);

  assign irq    = irq_pend & ien;
  assign status = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uncached  <= 1'b0;
      path_hold <= 1'b1;
      ien       <= 1'b0;
      cnt_lim   <= 8'(DEF_CNT_LIM);
      time_lim  <= 8'(DEF_TIME_LIM);
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: begin
          uncached  <= uncached  | reg_wdata[16];
          path_hold <= path_hold | reg_wdata[17];
          ien       <= ien       | reg_wdata[18];
        end
        2'd1: begin
          uncached  <= uncached  & ~reg_wdata[16];
          path_hold <= path_hold & ~reg_wdata[17];
          ien       <= ien       & ~reg_wdata[18];
        end
        2'd2: begin
          cnt_lim  <= reg_wdata[7:0];
          time_lim <= reg_wdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      ticks    <= '0;
      tag      <= '0;
      armed    <= 1'b0;
      irq_pend <= 1'b0;
      link_q   <= 1'b0;
      status_q <= '0;
    end else begin
      if (path_hold)                  pend <= '0;
      else if (fire)                  pend <= CNT_W'(msg_in);
      else if (msg_in && pend != CNT_MAX) pend <= pend + 1'b1;

      if (path_hold || fire || ack_hit || pend == '0) ticks <= '0;
      else if (tick && ticks != 8'hFF)                ticks <= ticks + 8'd1;

      if (fire) begin
        status_q <= {15'd0, link_q | tx_link, 5'd0, cnt7, tag};
        link_q   <= 1'b0;
        armed    <= 1'b0;
        irq_pend <= 1'b1;
      end else begin
        if (tx_link && !path_hold) link_q <= 1'b1;
        if (ack_hit) begin
          armed    <= 1'b1;
          irq_pend <= 1'b0;
          tag      <= tag + 4'd1;
        end else if (path_hold) begin
          irq_pend <= 1'b0;
        end
      end
    end
  end

  assert_held_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (path_hold && $past(path_hold)) |-> !irq);
  assert_status_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !$past(armed)) |-> $stable(status_q));
  assert_ack_rearms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (armed && !irq));
  assert_bad_ack_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd3 && reg_wdata[3:0] != tag + 4'd1) |=> $stable(tag));
  assert_count_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !path_hold && pend != '0 && pend >= CNT_W'(cnt_lim)) |=> (!armed && status_q[3:0] == $past(tag)));
endmodule

// File: tb/sim_rx_irq_coalescer.sv
module sim_rx_irq_coalescer;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, msg_in = 0, tx_link = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic irq, uncached, path_hold;
  logic [31:0] status;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] etag = 0;
  localparam int VEC [4] = '{1, 3, 5, 9};

  always #2.5 clk = ~clk;

  rx_irq_coalescer #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .msg_in(msg_in), .tx_link(tx_link), .irq(irq), .status(status),
    .uncached(uncached), .path_hold(path_hold));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); msg_in = 1; end
    @(negedge clk); msg_in = 0;
  endtask

  task automatic ack();
    etag = etag + 4'd1;
    wr(2'd3, {28'd0, etag});
  endtask

  function automatic logic [31:0] st(logic lk, int n, logic [3:0] t);
    return {15'd0, lk, 5'd0, 7'(n), t};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 status", status, 0);
    chk("R1 path_hold", path_hold, 1);
    chk("R1 uncached", uncached, 0);

    wr(2'd0, 32'h4_0000);
    wr(2'd1, 32'h2_0000);
    chk("R11 path_hold clr", path_hold, 0);
    ack();
    send(15); @(negedge clk);
    chk("R1 default limit 16 not reached", irq, 0);
    send(1); @(negedge clk);
    chk("R1 R2 irq at 16", irq, 1);
    chk("R1 R2 status", status, st(0, 16, etag));
    ack(); chk("R4 irq drop", irq, 0);

    wr(2'd0, 32'h1_0000); chk("R11 uncached set", uncached, 1);
    wr(2'd1, 32'h1_0000); chk("R11 uncached clr", uncached, 0);

    wr(2'd0, 32'h2_0000); chk("R11 path_hold set", path_hold, 1);
    wr(2'd2, 32'h0000_FF01);
    send(2); repeat (3) @(negedge clk);
    chk("R7 no irq in reset", irq, 0);
    wr(2'd1, 32'h2_0000); repeat (4) @(negedge clk);
    chk("R7 pending cleared", irq, 0);

    for (int v = 0; v < 4; v++) begin
      wr(2'd2, 32'h0000_FF00 | VEC[v]);
      send(VEC[v]); @(negedge clk);
      chk("R2 vector irq", irq, 1);
      chk("R2 vector status", status, st(0, VEC[v], etag));
      ack(); chk("R4 vector irq drop", irq, 0);
    end

    wr(2'd2, 32'h0000_FF01);
    send(1); @(negedge clk);
    s = status;
    chk("R2 single", s, st(0, 1, etag));
    wr(2'd3, {28'd0, etag + 4'd2}); @(negedge clk);
    chk("R5 bad ack irq", irq, 1);
    wr(2'd3, {28'd0, etag}); @(negedge clk);
    chk("R5 bad ack status", status, s);
    send(3); @(negedge clk);
    chk("R6 frozen status", status, s);
    chk("R6 irq held", irq, 1);
    ack();
    chk("R4 drop before next batch", irq, 0);
    @(negedge clk);
    chk("R6 accumulated batch", status, st(0, 3, etag));
    chk("R6 next irq", irq, 1);

    wr(2'd1, 32'h4_0000); chk("R8 ien clr", irq, 0);
    wr(2'd0, 32'h4_0000); chk("R8 ien set", irq, 1);
    ack();

    @(negedge clk); tx_link = 1; @(negedge clk); tx_link = 0;
    send(1); @(negedge clk);
    chk("R9 link set", status, st(1, 1, etag));
    ack(); send(1); @(negedge clk);
    chk("R9 link cleared", status, st(0, 1, etag));
    ack();

    wr(2'd2, 32'h0000_0310);
    send(1);
    repeat (9) @(negedge clk);
    chk("R3 not yet", irq, 0);
    repeat (6) @(negedge clk);
    chk("R3 timeout irq", irq, 1);
    chk("R3 status", status, st(0, 1, etag));
    ack();

    wr(2'd2, 32'h0000_FFC8);
    send(200); @(negedge clk);
    chk("R10 saturated", status, st(0, 127, etag));
    ack();

    wr(2'd2, 32'h0000_FF01);
    for (int b = 0; b < 18; b++) begin
      send(1); @(negedge clk);
      chk("R4 wrap tag", status, st(0, 1, etag));
      ack();
    end
    chk("R4 irq after wrap", irq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule